// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Burst SRAM

A synchronous single-port memory model that accepts one command per clock edge. A command is a load read, a load write, a burst continuation, a deselect or a no-op. Reads and writes can follow each other back to back with no idle cycle between them. Both kinds of command move through one shared two-stage pipeline, so the data for any command sits on the bus exactly two active clock edges after the edge that sampled the command. For a read, the data is driven out after that edge. For a write, the data is sampled on that edge.

Each word is 36 bits, made of four 9-bit lanes (8 data bits and 1 parity bit per lane), and each lane has its own write enable. An internal counter produces the follow-on addresses of a burst. The counter wraps linearly inside an aligned block of four words. A freeze input blocks a clock edge entirely. The bus driver appears as a data output plus a separate output-enable flag.

Top module: `zbt_sram`

## Requirements
- R1: With `freeze` low, the chip selected and `burst_adv` low, the edge loads `addr`. A load read is issued when `write_n` is 1 and a load write when `write_n` is 0.
- R2: Read data appears on `dout` with `dout_oe` high after the second active edge following the command. Write data is sampled from `din` on that second active edge.
- R3: With `burst_adv` high during an active burst, the next address comes from the burst counter. `write_n` is ignored and the burst keeps the direction of its load cycle.
- R4: Burst addresses step linearly on the two low address bits, modulo 4, starting from the load address. The upper address bits stay fixed.
- R5: The chip is selected only when `sel0_n`=0, `sel1_n`=0 and `sel2`=1. Any other combination with `burst_adv` low is a deselect: it ends any burst, and `dout_oe` is low in its data slot.
- R6: `burst_adv` high with no active burst (after reset or a deselect) is a no-op, and `dout_oe` is low in its data slot.
- R7: `freeze` high blocks the edge. The pipeline, the burst state, the memory, `dout` and `dout_oe` all keep their values.
- R8: Lane i covers `din`/`dout` bits [9i+8:9i] and is written only when `lane_wr_n[i]`=0. Lane enables travel with the command. Any mix of lanes may be written, and with all four enables at 1 a write changes nothing.
- R9: While `rst_n` is low at an edge, the pipeline and burst state are cleared and `dout_oe` is 0 after that edge.
- R10: Reads and writes may alternate on consecutive edges. A read issued on the edge right after a write to the same address returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| freeze | input | 1 | High blocks the current edge |
| sel0_n | input | 1 | Active-low chip select 0 |
| sel1_n | input | 1 | Active-low chip select 1 |
| sel2 | input | 1 | Active-high chip select 2 |
| burst_adv | input | 1 | 1 = continue burst, 0 = load or deselect |
| write_n | input | 1 | Direction on load: 0 write, 1 read |
| addr | input | ADDR_W | External word address |
| lane_wr_n | input | LANES | Active-low lane write enables |
| din | input | 36 | Write data, sampled in the write slot |
| dout | output | 36 | Read data |
| dout_oe | output | 1 | High when the bus carries read data |

## Verification
A stage register or burst counter holding a wrong value shows up within two active edges. The symptoms are a read slot with the wrong word, a missing or extra `dout_oe` pulse, or a write that lands at the wrong address and surfaces at the next read of that address. A freeze that leaks through shifts every later data slot by one cycle, so every following comparison breaks. The bench checks `dout_oe` on every cycle and `dout` in every read slot against a behavioural model. The model covers bursts across the wrap point, partial lane masks, and freezes placed over both read and write slots.

// File: rtl/zbt_pkg.sv
// Shared types for the pipelined burst SRAM.
package zbt_pkg;
    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_READ  = 2'd1,
        SLOT_WRITE = 2'd2
    } slot_e;

    // Number of low address bits the burst counter walks through.
    localparam int WRAP_BITS = 2;
endpackage

// File: rtl/zbt_cmd_decode.sv
// Command decoder and burst address generator.
// Turns the control pins of one edge into a slot operation and an address.
// Assumes ADDR_W > WRAP_BITS. State advances only on edges with freeze low.
module zbt_cmd_decode
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              sel0_n,
    input  logic              sel1_n,
    input  logic              sel2,
    input  logic              burst_adv,
    input  logic              write_n,
    input  logic [ADDR_W-1:0] addr,
    output slot_e             op,
    output logic [ADDR_W-1:0] op_addr
);
    logic                 selected;
    logic                 burst_act;
    logic                 burst_wr;
    logic [ADDR_W-1:0]    burst_base;
    logic [WRAP_BITS-1:0] burst_cnt;
    logic [WRAP_BITS-1:0] nxt_cnt;

    assign selected = !sel0_n && !sel1_n && sel2;
    assign nxt_cnt  = burst_cnt + 1'b1;

    // Decode this edge's command and form its address.
    always_comb begin
        op      = SLOT_IDLE;
        op_addr = addr;
        if (!burst_adv) begin
            if (selected) op = write_n ? SLOT_READ : SLOT_WRITE;
        end else if (burst_act) begin
            op      = burst_wr ? SLOT_WRITE : SLOT_READ;
            op_addr = {burst_base[ADDR_W-1:WRAP_BITS],
                       burst_base[WRAP_BITS-1:0] + nxt_cnt};
        end
    end

    // Track the active burst: start on load, step on advance, end on deselect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_act  <= 1'b0;
            burst_wr   <= 1'b0;
            burst_base <= '0;
            burst_cnt  <= '0;
        end else if (!freeze) begin
            if (!burst_adv) begin
                burst_act <= selected;
                if (selected) begin
                    burst_wr   <= !write_n;
                    burst_base <= addr;
                    burst_cnt  <= '0;
                end
            end else if (burst_act) begin
                burst_cnt <= nxt_cnt;
            end
        end
    end

    // R5
    desel_ends_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !burst_adv && !selected) |=> !burst_act);

    // R7
    freeze_holds_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(burst_cnt) && $stable(burst_act) && $stable(burst_base)));
endmodule

// File: rtl/zbt_pipe.sv
// Two-stage command pipeline shared by reads and writes.
// Stage 0 holds the command from the last active edge; the final stage
// names the operation whose data slot is the next active edge.
module zbt_pipe
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  slot_e             in_op,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]  in_lane_n,
    output slot_e             s1_op,
    output logic [ADDR_W-1:0] s1_addr,
    output slot_e             s2_op,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_lane_n
);
    localparam int LAST = STAGES - 1;

    slot_e             op_q   [STAGES];
    logic [ADDR_W-1:0] addr_q [STAGES];
    logic [LANES-1:0]  lane_q [STAGES];

    // Shift commands one stage per active edge; a frozen edge holds them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                op_q[i]   <= SLOT_IDLE;
                addr_q[i] <= '0;
                lane_q[i] <= '1;
            end
        end else if (!freeze) begin
            op_q[0]   <= in_op;
            addr_q[0] <= in_addr;
            lane_q[0] <= in_lane_n;
            for (int i = 1; i < STAGES; i++) begin
                op_q[i]   <= op_q[i-1];
                addr_q[i] <= addr_q[i-1];
                lane_q[i] <= lane_q[i-1];
            end
        end
    end

    assign s1_op     = op_q[LAST-1];
    assign s1_addr   = addr_q[LAST-1];
    assign s2_op     = op_q[LAST];
    assign s2_addr   = addr_q[LAST];
    assign s2_lane_n = lane_q[LAST];

    // R2
    stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !freeze |=> (s2_op == $past(s1_op)));
endmodule

// File: rtl/zbt_array.sv
// Lane-masked storage with a registered read port.
// The read is taken one edge before its data slot; a write landing on that
// same edge to the same word is merged lane by lane into the read result.
module zbt_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    freeze,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        wr_lane_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int WORD_W = LANES * LANE_W;
    localparam int WORDS  = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [WORDS];
    logic [WORD_W-1:0] fwd_word;
    logic              hit;

    assign hit = wr_en && (wr_addr == rd_addr);

    // Per-lane choice between the stored lane and a lane written on this edge.
    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign fwd_word[l*LANE_W +: LANE_W] =
            (hit && !wr_lane_n[l]) ? wr_data[l*LANE_W +: LANE_W]
                                   : mem[rd_addr][l*LANE_W +: LANE_W];
    end

    // Write the enabled lanes of the slot's word.
    always_ff @(posedge clk) begin
        if (rst_n && !freeze && wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                if (!wr_lane_n[l])
                    mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
            end
        end
    end

    // Capture the read word one edge ahead of its slot.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else if (!freeze && rd_en)
            rd_data <= fwd_word;
    end
endmodule

// File: rtl/zbt_sram.sv
// Top level: pipelined burst SRAM with no bus turnaround.
// Commands enter the decoder, run through the two-stage pipe, and meet
// their data two active edges later. dout/dout_oe stand in for a tri-state
// driver; dout_oe low means the bus is released.
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    freeze,
    input  logic                    sel0_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    burst_adv,
    input  logic                    write_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);
    localparam int DATA_W = LANES * LANE_W;

    slot_e             dec_op;
    logic [ADDR_W-1:0] dec_addr;
    slot_e             s1_op;
    logic [ADDR_W-1:0] s1_addr;
    slot_e             s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_lane_n;
    logic [DATA_W-1:0] rd_word;

    zbt_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .freeze(freeze),
        .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2(sel2),
        .burst_adv(burst_adv), .write_n(write_n), .addr(addr),
        .op(dec_op), .op_addr(dec_addr)
    );

    zbt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .STAGES(2)) u_pipe (
        .clk(clk), .rst_n(rst_n), .freeze(freeze),
        .in_op(dec_op), .in_addr(dec_addr), .in_lane_n(lane_wr_n),
        .s1_op(s1_op), .s1_addr(s1_addr),
        .s2_op(s2_op), .s2_addr(s2_addr), .s2_lane_n(s2_lane_n)
    );

    zbt_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .freeze(freeze),
        .rd_en(s1_op == SLOT_READ), .rd_addr(s1_addr),
        .wr_en(s2_op == SLOT_WRITE), .wr_addr(s2_addr),
        .wr_lane_n(s2_lane_n), .wr_data(din),
        .rd_data(rd_word)
    );

    // Drive the bus in a read slot, release it in any other slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_oe <= 1'b0;
            dout    <= '0;
        end else if (!freeze) begin
            dout_oe <= (s2_op == SLOT_READ);
            if (s2_op == SLOT_READ) dout <= rd_word;
        end
    end

    // R9
    reset_release_chk: assert property (@(posedge clk)
        !rst_n |=> !dout_oe);

    // R7
    freeze_bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ($stable(dout_oe) && $stable(dout)));

    // R3
    burst_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && burst_adv && dec_op != SLOT_IDLE) |=> (s1_op == $past(s1_op)));

    // R4
    burst_upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && burst_adv && dec_op != SLOT_IDLE)
        |=> (s1_addr[ADDR_W-1:WRAP_BITS] == $past(s1_addr[ADDR_W-1:WRAP_BITS])));

    // R6
    noop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && burst_adv && s1_op == SLOT_IDLE && s2_op == SLOT_IDLE
         && dec_op == SLOT_IDLE) |=> (s1_op == SLOT_IDLE));
endmodule

// File: tb/tb_zbt_sram.sv
module tb_zbt_sram;
    localparam int AW = 10;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          freeze = 1'b0;
    logic          sel0_n = 1'b1, sel1_n = 1'b1, sel2 = 1'b0;
    logic          burst_adv = 1'b0, write_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] lane_wr_n = '1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    zbt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .freeze(freeze),
        .sel0_n(sel0_n), .sel1_n(sel1_n), .sel2(sel2),
        .burst_adv(burst_adv), .write_n(write_n), .addr(addr),
        .lane_wr_n(lane_wr_n), .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string tag = "R9";

    // Reference model state: 0 idle, 1 read, 2 write.
    logic [DW-1:0] mm [int];
    int            q_op [2];
    int            q_addr [2];
    logic [NL-1:0] q_lane [2];
    bit            b_act = 0, b_wr = 0;
    int            b_base = 0, b_cnt = 0;
    bit            exp_oe = 0;
    logic [DW-1:0] exp_dout = '0;

    task automatic chk(bit ok, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge();
        int nop, na;
        bit sel;
        logic [DW-1:0] w;
        if (!rst_n) begin
            q_op[0] = 0; q_op[1] = 0;
            b_act = 0; b_cnt = 0; exp_oe = 0;
        end else if (!freeze) begin
            if (q_op[1] == 2) begin
                w = mm.exists(q_addr[1]) ? mm[q_addr[1]] : 'x;
                for (int l = 0; l < NL; l++)
                    if (!q_lane[1][l]) w[l*LW +: LW] = din[l*LW +: LW];
                mm[q_addr[1]] = w;
            end
            if (q_op[1] == 1) begin
                exp_oe = 1;
                exp_dout = mm.exists(q_addr[1]) ? mm[q_addr[1]] : 'x;
            end else exp_oe = 0;
            sel = !sel0_n && !sel1_n && sel2;
            nop = 0; na = int'(addr);
            if (!burst_adv) begin
                if (sel) begin
                    nop = write_n ? 1 : 2;
                    b_act = 1; b_wr = !write_n; b_base = int'(addr); b_cnt = 0;
                end else b_act = 0;
            end else if (b_act) begin
                b_cnt = (b_cnt + 1) % 4;
                na = (b_base & ~3) | ((b_base + b_cnt) & 3);
                nop = b_wr ? 2 : 1;
            end
            q_op[1] = q_op[0]; q_addr[1] = q_addr[0]; q_lane[1] = q_lane[0];
            q_op[0] = nop; q_addr[0] = na; q_lane[0] = lane_wr_n;
        end
    endtask

    task automatic step(bit fz, bit s0, bit s1, bit s2, bit adv, bit wn,
                        int a, logic [NL-1:0] ln);
        freeze = fz; sel0_n = s0; sel1_n = s1; sel2 = s2;
        burst_adv = adv; write_n = wn; addr = AW'(a); lane_wr_n = ln;
        din = {$urandom, $urandom};
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk(dout_oe === exp_oe, "dout_oe", DW'(dout_oe), DW'(exp_oe));
        if (exp_oe) chk(dout === exp_dout, "dout", dout, exp_dout);
    endtask

    task automatic ld_wr(int a, logic [NL-1:0] ln = '0); step(0,0,0,1,0,0,a,ln); endtask
    task automatic ld_rd(int a); step(0,0,0,1,0,1,a,'0); endtask
    task automatic adv(bit wn); step(0,0,0,1,1,wn,0,'0); endtask
    task automatic desel(); step(0,1,1,0,0,1,0,'1); endtask
    task automatic frz(); step(1,0,0,1,0,0,7,'0); endtask

    initial begin
        q_op[0] = 0; q_op[1] = 0; q_lane[0] = '1; q_lane[1] = '1;
        q_addr[0] = 0; q_addr[1] = 0;
        // R9: reset clears the bus enable
        tag = "R9";
        for (int i = 0; i < 3; i++) desel();
        rst_n = 1'b1;
        desel(); desel();
        // R1: load writes back to back, full lanes
        tag = "R1";
        for (int i = 0; i < 16; i++) ld_wr(i);
        desel(); desel();
        // R10: reads and writes interleaved on consecutive edges
        tag = "R10";
        for (int i = 0; i < 16; i++) begin ld_rd(i); ld_wr(i + 16); end
        ld_wr(5); ld_rd(5); ld_rd(5); ld_wr(17); ld_rd(17);
        desel(); desel();
        // R2: single read, then released bus
        tag = "R2";
        ld_rd(3); desel(); desel(); desel();
        // R8: lane masks, including none
        tag = "R8";
        ld_wr(20, 4'b1010); ld_wr(20, 4'b0110); ld_rd(20);
        ld_wr(3, 4'b1111); ld_wr(21, 4'b1110); ld_rd(3); ld_rd(21);
        desel(); desel();
        // R3: write burst with write_n toggled, read burst with write_n low
        tag = "R3";
        ld_wr(6); adv(1); adv(0); adv(1);
        ld_rd(6); adv(0); adv(0); adv(0);
        desel(); desel();
        // R4: read burst across the wrap point of a 4-word block
        tag = "R4";
        ld_rd(13); for (int i = 0; i < 5; i++) adv(1);
        desel(); desel();
        // R5: each false select ends the burst and gives an idle slot
        tag = "R5";
        ld_rd(1); step(0,1,0,1,0,1,2,'0); adv(1);
        ld_rd(2); step(0,0,1,1,0,0,2,'0); adv(0);
        ld_rd(4); step(0,0,0,0,0,1,2,'0); adv(1);
        desel(); desel();
        // R6: advance with no active burst is a no-op
        tag = "R6";
        adv(1); adv(0); adv(1); desel(); desel();
        // R7: freeze over a read slot and over a write slot
        tag = "R7";
        ld_rd(2); adv(1); frz(); frz(); adv(1); frz(); desel(); frz(); desel(); desel();
        ld_wr(9); desel(); frz(); frz(); desel(); ld_rd(9); desel(); desel(); desel();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule